// File: doc/BRIEF.md
# Register Renamer with Free Pool

This block turns the architectural register numbers of a group of decoded instructions into physical register numbers, so that later out-of-order execution sees no false write-after-read or write-after-write dependences. A map table holds the physical register currently standing for each architectural register. A circular pool holds the physical registers that nobody owns. Every source is translated by looking it up. Every destination is handed a fresh register from the pool.

Each renamed destination also reports the physical register it displaced. The pipeline carries that number with the instruction. When the instruction retires, the number comes back on a retire lane and is appended to the pool. Up to `WIDTH` instructions are renamed per cycle. A whole group is held back when the pool cannot cover all of its destinations. Recovery from a misprediction is done only by a full reset.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds physical registers ARCH to PHYS-1 and hands them out in ascending order.
- R2: Source physical outputs are combinational lookups of the map table for the presented source numbers in the same cycle.
- R3: Each lane with both `renValid` and `dstValid` set receives the next pool entry. Lane 0 is served first, and entries leave the pool in first-in first-out order. No register handed out is currently mapped, and no two lanes of one group get the same register.
- R4: `prevPhys` of a destination lane is the mapping that lane replaces. When an earlier lane of the same group writes the same architectural register, it is that lane's new register.
- R5: A source in lane j that names the destination of an earlier lane k < j of the same group reads that lane's new register, taking the highest such k. A lane's own destination does not affect its own sources.
- R6: An accepted group updates the map at the next clock edge. When two lanes write the same architectural register, the higher lane's register remains mapped.
- R7: `stall` is high exactly when the number of lanes with both `renValid` and `dstValid` exceeds the pool count at the start of the cycle. A stalled group changes neither the map nor the pool. Lanes without a valid destination consume nothing.
- R8: Each lane with `retValid` appends `retPhys` to the pool tail in lane order. The entry can be allocated from the next cycle on, and not in the cycle of its retirement.
- R9: The pool count never exceeds PHYS-ARCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | WIDTH | Lane carries an instruction to rename |
| srcArchA | input | WIDTH*AW | First source architectural register per lane |
| srcArchB | input | WIDTH*AW | Second source architectural register per lane |
| dstValid | input | WIDTH | Lane has a destination register |
| dstArch | input | WIDTH*AW | Destination architectural register per lane |
| retValid | input | WIDTH | Retire lane returns a register to the pool |
| retPhys | input | WIDTH*PW | Physical register being returned |
| srcPhysA | output | WIDTH*PW | Renamed first source |
| srcPhysB | output | WIDTH*PW | Renamed second source |
| allocPhys | output | WIDTH*PW | Newly allocated destination register |
| prevPhys | output | WIDTH*PW | Displaced mapping of the destination |
| stall | output | 1 | Group cannot be accepted this cycle |

## Verification
The bench builds the renamer with 4 architectural registers, 8 physical registers and 2 lanes. With these values the pool holds only four entries, so two full groups empty it. Stalls, a retirement in the same cycle as a stalled request, and wrap-around of the circular pool all occur within a few dozen cycles. With only four architectural names, random groups often collide, so same-group bypass and same-destination ordering are exercised often.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int MAX_LANES = 4;

  typedef struct packed {
    logic                 commit;
    logic [MAX_LANES-1:0] takeFree;
    logic [MAX_LANES-1:0] giveBack;
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int ARCH  = 32,
  parameter int PHYS  = 64,
  parameter int WIDTH = 4,
  localparam int CW = $clog2(PHYS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] renValid,
  input  logic [WIDTH-1:0] dstValid,
  input  logic [WIDTH-1:0] retValid,
  output logic             stall,
  output renStrobe_t       strobe
);
  localparam logic [CW-1:0] FREE_INIT = CW'(PHYS - ARCH);

  logic [CW-1:0]    freeCnt;
  logic [CW-1:0]    demand;
  logic [CW-1:0]    returned;
  logic [WIDTH-1:0] wantDst;

  assign wantDst = renValid & dstValid;

  always_comb begin
    demand   = '0;
    returned = '0;
    for (int l = 0; l < WIDTH; l++) begin
      if (wantDst[l])  demand   = demand + CW'(1);
      if (retValid[l]) returned = returned + CW'(1);
    end
  end

  assign stall = demand > freeCnt;

  always_comb begin
    strobe          = '0;
    strobe.commit   = !stall && (|wantDst);
    strobe.giveBack[WIDTH-1:0] = retValid;
    if (strobe.commit) strobe.takeFree[WIDTH-1:0] = wantDst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) freeCnt <= FREE_INIT;
    else       freeCnt <= freeCnt - (strobe.commit ? demand : '0) + returned;
  end

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt <= FREE_INIT); // R9
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int ARCH  = 32,
  parameter int PHYS  = 64,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  renStrobe_t                strobe,
  input  logic [WIDTH-1:0][AW-1:0]  srcArchA,
  input  logic [WIDTH-1:0][AW-1:0]  srcArchB,
  input  logic [WIDTH-1:0][AW-1:0]  dstArch,
  input  logic [WIDTH-1:0][PW-1:0]  retPhys,
  output logic [WIDTH-1:0][PW-1:0]  srcPhysA,
  output logic [WIDTH-1:0][PW-1:0]  srcPhysB,
  output logic [WIDTH-1:0][PW-1:0]  allocPhys,
  output logic [WIDTH-1:0][PW-1:0]  prevPhys
);
  logic [ARCH-1:0][PW-1:0]  mapTbl;
  logic [PHYS-1:0][PW-1:0]  freeRing;
  logic [PW-1:0]            head, tail;
  logic [PW-1:0]            popCnt, pushCnt;
  logic [WIDTH-1:0][PW-1:0] pushAddr;

  // pool read side: lanes take consecutive head entries
  always_comb begin
    popCnt = '0;
    for (int l = 0; l < WIDTH; l++) begin
      allocPhys[l] = freeRing[head + popCnt];
      if (strobe.takeFree[l]) popCnt = popCnt + PW'(1);
    end
  end

  // pool write side: retire lanes pack onto the tail
  always_comb begin
    pushCnt = '0;
    for (int l = 0; l < WIDTH; l++) begin
      pushAddr[l] = tail + pushCnt;
      if (strobe.giveBack[l]) pushCnt = pushCnt + PW'(1);
    end
  end

  // lookups with bypass from earlier lanes of the group
  always_comb begin
    for (int l = 0; l < WIDTH; l++) begin
      srcPhysA[l] = mapTbl[srcArchA[l]];
      srcPhysB[l] = mapTbl[srcArchB[l]];
      prevPhys[l] = mapTbl[dstArch[l]];
      for (int k = 0; k < WIDTH; k++) begin
        if (k < l && strobe.takeFree[k]) begin
          if (dstArch[k] == srcArchA[l]) srcPhysA[l] = allocPhys[k];
          if (dstArch[k] == srcArchB[l]) srcPhysB[l] = allocPhys[k];
          if (dstArch[k] == dstArch[l])  prevPhys[l] = allocPhys[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH; i++) mapTbl[i] <= PW'(i);
      for (int i = 0; i < PHYS; i++)
        freeRing[i] <= (i < PHYS - ARCH) ? PW'(i + ARCH) : '0;
      head <= '0;
      tail <= PW'(PHYS - ARCH);
    end else begin
      for (int l = 0; l < WIDTH; l++) begin
        if (strobe.takeFree[l]) mapTbl[dstArch[l]] <= allocPhys[l];
        if (strobe.giveBack[l]) freeRing[pushAddr[l]] <= retPhys[l];
      end
      head <= head + popCnt;
      tail <= tail + pushCnt;
    end
  end

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(mapTbl)); // R7

  for (genvar l = 0; l < WIDTH; l++) begin : g_laneChk
    for (genvar a = 0; a < ARCH; a++) begin : g_archChk
      AST_FRESH_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
        strobe.takeFree[l] |-> allocPhys[l] != mapTbl[a]); // R3
    end
    for (genvar k = l + 1; k < WIDTH; k++) begin : g_pairChk
      AST_DISTINCT_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.takeFree[l] && strobe.takeFree[k]) |-> allocPhys[l] != allocPhys[k]); // R3
    end
  end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rename_pkg::*;
#(
  parameter int ARCH  = 32,
  parameter int PHYS  = 64,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIDTH-1:0]         renValid,
  input  logic [WIDTH-1:0][AW-1:0] srcArchA,
  input  logic [WIDTH-1:0][AW-1:0] srcArchB,
  input  logic [WIDTH-1:0]         dstValid,
  input  logic [WIDTH-1:0][AW-1:0] dstArch,
  input  logic [WIDTH-1:0]         retValid,
  input  logic [WIDTH-1:0][PW-1:0] retPhys,
  output logic [WIDTH-1:0][PW-1:0] srcPhysA,
  output logic [WIDTH-1:0][PW-1:0] srcPhysB,
  output logic [WIDTH-1:0][PW-1:0] allocPhys,
  output logic [WIDTH-1:0][PW-1:0] prevPhys,
  output logic                     stall
);
  renStrobe_t strobe;

  rename_ctrl #(.ARCH(ARCH), .PHYS(PHYS), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .dstValid(dstValid),
    .retValid(retValid), .stall(stall), .strobe(strobe)
  );

  rename_datapath #(.ARCH(ARCH), .PHYS(PHYS), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcArchA(srcArchA), .srcArchB(srcArchB), .dstArch(dstArch),
    .retPhys(retPhys), .srcPhysA(srcPhysA), .srcPhysB(srcPhysB),
    .allocPhys(allocPhys), .prevPhys(prevPhys)
  );
endmodule

// File: tb/reg_renamer_bench.sv
`timescale 1ns/1ps
module reg_renamer_bench;
  localparam int ARCH = 4, PHYS = 8, WIDTH = 2, AW = 2, PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [WIDTH-1:0]         renValid, dstValid, retValid;
  logic [WIDTH-1:0][AW-1:0] srcArchA, srcArchB, dstArch;
  logic [WIDTH-1:0][PW-1:0] retPhys, srcPhysA, srcPhysB, allocPhys, prevPhys;
  logic                     stall;

  reg_renamer #(.ARCH(ARCH), .PHYS(PHYS), .WIDTH(WIDTH)) u_reg_renamer (
    .clk(clk), .rstN(rstN), .renValid(renValid), .srcArchA(srcArchA),
    .srcArchB(srcArchB), .dstValid(dstValid), .dstArch(dstArch),
    .retValid(retValid), .retPhys(retPhys), .srcPhysA(srcPhysA),
    .srcPhysB(srcPhysB), .allocPhys(allocPhys), .prevPhys(prevPhys),
    .stall(stall)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int mapM [ARCH];
  int freeQ [$];
  int pendQ [$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    renValid = '0; dstValid = '0; retValid = '0;
    srcArchA = '0; srcArchB = '0; dstArch = '0; retPhys = '0;
  endtask

  task automatic setLane(int l, bit v, int a, int b, bit dv, int d);
    renValid[l] = v; srcArchA[l] = AW'(a); srcArchB[l] = AW'(b);
    dstValid[l] = dv; dstArch[l] = AW'(d);
  endtask

  task automatic retireSome(int n);
    for (int l = 0; l < WIDTH; l++) begin
      if (l < n && pendQ.size() > 0) begin
        retValid[l] = 1'b1;
        retPhys[l]  = PW'(pendQ.pop_front());
      end
    end
  endtask

  // reference step: called at a falling edge with inputs already driven
  task automatic runCycle();
    int demand = 0;
    int idx = 0;
    int tmp [ARCH];
    bit expStall;
    #1;
    for (int l = 0; l < WIDTH; l++) if (renValid[l] && dstValid[l]) demand++;
    expStall = demand > freeQ.size();
    check("R7/R9 stall", int'(stall), int'(expStall));
    tmp = mapM;
    if (!expStall) begin
      for (int l = 0; l < WIDTH; l++) begin
        if (renValid[l]) begin
          check("R2/R5/R6 srcA", int'(srcPhysA[l]), tmp[srcArchA[l]]);
          check("R2/R5/R6 srcB", int'(srcPhysB[l]), tmp[srcArchB[l]]);
          if (dstValid[l]) begin
            check("R1/R3/R8 alloc", int'(allocPhys[l]), freeQ[idx]);
            check("R4 prev", int'(prevPhys[l]), tmp[dstArch[l]]);
            pendQ.push_back(tmp[dstArch[l]]);
            tmp[dstArch[l]] = freeQ[idx];
            idx++;
          end
        end
      end
      repeat (demand) void'(freeQ.pop_front());
      mapM = tmp;
    end else if (renValid[0]) begin
      check("R2/R7 srcA held", int'(srcPhysA[0]), mapM[srcArchA[0]]);
    end
    for (int l = 0; l < WIDTH; l++) if (retValid[l]) freeQ.push_back(int'(retPhys[l]));
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: identity map visible right after reset
    srcArchA[0] = 2'd0; srcArchA[1] = 2'd1; srcArchB[0] = 2'd2; srcArchB[1] = 2'd3;
    #1;
    check("R1 map0", int'(srcPhysA[0]), 0);
    check("R1 map1", int'(srcPhysA[1]), 1);
    check("R1 map2", int'(srcPhysB[0]), 2);
    check("R1 map3", int'(srcPhysB[1]), 3);
    check("R1 stall", int'(stall), 0);
    @(negedge clk);
    for (int i = 0; i < ARCH; i++) mapM[i] = i;
    for (int i = ARCH; i < PHYS; i++) freeQ.push_back(i);

    // R5 bypass: lane1 reads the register lane0 writes
    clearIn(); setLane(0, 1, 0, 2, 1, 1); setLane(1, 1, 1, 1, 1, 3); runCycle();
    // R6: both lanes write register 2, then read it
    clearIn(); setLane(0, 1, 3, 0, 1, 2); setLane(1, 1, 2, 0, 1, 2); runCycle();
    clearIn(); setLane(0, 1, 2, 3, 0, 0); setLane(1, 1, 1, 2, 0, 0); runCycle();
    // R7: pool is now empty, further groups stall and change nothing
    clearIn(); setLane(0, 1, 1, 2, 1, 0); runCycle();
    clearIn(); setLane(0, 1, 2, 3, 1, 2); setLane(1, 1, 0, 1, 1, 1); runCycle();
    // R8: same-cycle return cannot be used, next cycle it can
    clearIn(); setLane(0, 1, 0, 0, 1, 3); retireSome(1); runCycle();
    clearIn(); setLane(0, 1, 3, 0, 1, 3); runCycle();
    // R9: return everything, then exactly PHYS-ARCH allocations fit
    clearIn(); retireSome(2); runCycle();
    clearIn(); retireSome(2); runCycle();
    clearIn(); retireSome(2); runCycle();
    clearIn(); setLane(0, 1, 0, 1, 1, 0); setLane(1, 1, 0, 1, 1, 1); runCycle();
    clearIn(); setLane(0, 1, 2, 3, 1, 2); setLane(1, 1, 2, 3, 1, 3); runCycle();
    clearIn(); setLane(0, 1, 0, 0, 1, 0); runCycle();
    clearIn(); retireSome(2); runCycle();
    clearIn(); retireSome(2); runCycle();

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      clearIn();
      for (int l = 0; l < WIDTH; l++)
        setLane(l, bit'($urandom_range(0, 1)), int'($urandom_range(0, ARCH - 1)),
                int'($urandom_range(0, ARCH - 1)), bit'($urandom_range(0, 1)),
                int'($urandom_range(0, ARCH - 1)));
      retireSome(int'($urandom_range(0, 2)));
      runCycle();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule